// File: doc/BRIEF.md
# Serial I/Q Output Framer

This block takes a pair of already formatted sample words, one in-phase and one quadrature, and sends them out bit by bit on two serial data pins. The bit rate comes from a free-running phase counter on the system clock, and the same counter drives a companion bit clock pin. A word strobe pin marks where each word sits in time. Each word travels inside a frame: a zero bit, then the data bits from the least significant bit up, then a closing zero bit.

The two words can leave side by side, one on each pin, or one after the other on the in-phase pin alone. The bit clock can run all the time or only while a frame is on the wire. Its high phase can be about half the bit period or a single system clock, and its polarity can be inverted. The strobe can sit in the bit period just before a frame or cover the data bits of each word, and it can be active high or active low. Each of the four pins has a separate output-enable line for the pad ring.

A host writes both words with a one-cycle load pulse. If a frame is still being sent, the new pair waits in a holding register and goes out directly after the current frame's closing zero.

Top module: `iq_serial_framer`

## Requirements
- R1: A frame is a zero bit, then data bits from bit 0 upward, then a zero bit. The data width is set by `len_sel`: 00 gives 16 bits, 01 gives 24, 10 gives 32 and 11 gives 38.
- R2: When `cfg_iq_serial`=0, the I frame goes out on `i_out` and the Q frame goes out on `q_out` in the same bit periods.
- R3: When `cfg_iq_serial`=1, `i_out` carries the I frame and then the Q frame directly after it, and `q_out` stays 0.
- R4: For `cfg_rate` from 1 to 8191, a bit period lasts `cfg_rate`+1 system clocks. Periods come from a free-running phase counter. A frame's first bit starts at the first period boundary after the load is accepted. With rate 8191 and a continuous clock, any window of 16384 cycles holds exactly two rising edges of `iqclk_out`.
- R5: When `cfg_rate`=0, a bit lasts one system clock and `iqclk_out` stays at its inactive level.
- R6: When `cfg_clk_gated`=1, `iqclk_out` toggles only while frame bits are being sent. When it is 0, the clock runs whenever the rate is non-zero.
- R7: With `cfg_clk_pulse`=0, the raw clock is high for the last floor(P/2) cycles of each P-cycle bit period. With `cfg_clk_pulse`=1, it is high only in the last cycle. Setting `cfg_clk_inv` inverts the clock. The inactive level equals `cfg_clk_inv`.
- R8: When `cfg_stb_prior`=1, the strobe is active for exactly the one bit period before the first frame bit. When it is 0, the strobe is active during the data bits of each word, and not during the framing zeros.
- R9: Setting `cfg_stb_low`=1 makes the strobe active low. An idle strobe sits at its inactive level.
- R10: Each `*_oe` output follows its `cfg_en_*` input one clock later and is 0 during reset.
- R11: A pair loaded during a frame is held until that frame ends and goes out starting at the next boundary. A later load before then replaces the held pair.
- R12: Word length, pin mode and strobe timing are captured when a frame starts. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle pulse that writes a word pair |
| i_word | input | 38 | In-phase word, LSB aligned |
| q_word | input | 38 | Quadrature word, LSB aligned |
| len_sel | input | 2 | Data width code (16/24/32/38) |
| cfg_rate | input | 13 | Bit period minus one; 0 selects one bit per clock |
| cfg_iq_serial | input | 1 | 1: I then Q on the I pin |
| cfg_clk_gated | input | 1 | 1: bit clock only during frames |
| cfg_clk_pulse | input | 1 | 1: one-cycle high phase |
| cfg_clk_inv | input | 1 | Invert the bit clock |
| cfg_stb_prior | input | 1 | 1: strobe precedes the frame |
| cfg_stb_low | input | 1 | Active-low strobe |
| cfg_en_i | input | 1 | Drive enable request for `i_out` |
| cfg_en_q | input | 1 | Drive enable request for `q_out` |
| cfg_en_clk | input | 1 | Drive enable request for `iqclk_out` |
| cfg_en_stb | input | 1 | Drive enable request for `iqstb_out` |
| i_out | output | 1 | Serial in-phase data |
| q_out | output | 1 | Serial quadrature data |
| iqclk_out | output | 1 | Bit clock |
| iqstb_out | output | 1 | Word strobe |
| i_oe | output | 1 | Pad enable for `i_out` |
| q_oe | output | 1 | Pad enable for `q_out` |
| iqclk_oe | output | 1 | Pad enable for `iqclk_out` |
| iqstb_oe | output | 1 | Pad enable for `iqstb_out` |

## Verification
A load is recorded on the edge where it is sampled. The first frame bit, or the prior strobe, appears after the first clock edge on which the phase counter reaches `cfg_rate`. Every later bit follows `cfg_rate`+1 edges after the one before, and the pad enables follow their requests one edge later. A behavioural model in the bench applies these rules at each rising edge using queues of expected bits. The bench then compares every pin on the falling edge that follows, so each result is sampled in the cycle it is due and away from the edge that changes it. Directed checks add the reset state and an edge count over a long window at the slowest rate.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  localparam int WORD_MAX = 38;
  localparam int RATE_W   = 13;
  localparam int BIDX_W   = $clog2(2 * (WORD_MAX + 2));

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SEND} seq_st_t;

  // data bits per word for a length code
  function automatic logic [BIDX_W-1:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return BIDX_W'(16);
      2'b01:   return BIDX_W'(24);
      2'b10:   return BIDX_W'(32);
      default: return BIDX_W'(38);
    endcase
  endfunction

  // bits in a whole frame including framing zeros
  function automatic logic [BIDX_W-1:0] frame_bits(input logic [1:0] sel, input logic serial);
    logic [BIDX_W-1:0] slot;
    slot = word_bits(sel) + BIDX_W'(2);
    return serial ? (slot << 1) : slot;
  endfunction

  // raw (non-inverted) bit clock level for a phase within a period
  function automatic logic clk_level(input logic [RATE_W-1:0] ph,
                                     input logic [RATE_W-1:0] rate,
                                     input logic pulse);
    logic [RATE_W:0] period, half;
    period = {1'b0, rate} + 1'b1;
    half   = period >> 1;
    if (rate == '0) return 1'b0;
    if (pulse)      return ph == rate;
    return {1'b0, ph} >= (period - half);
  endfunction
endpackage

// File: rtl/iqf_rate_gen.sv
module iqf_rate_gen #(
  parameter int RATE_W = iqf_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              pulse,
  output logic              tick,
  output logic              raw_clk
);
  logic [RATE_W-1:0] ph;

  assign tick    = ph >= rate;
  assign raw_clk = iqf_pkg::clk_level(ph, rate, pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph <= '0;
    else if (tick) ph <= '0;
    else           ph <= ph + 1'b1;
  end
endmodule

// File: rtl/iqf_frame_seq.sv
module iqf_frame_seq #(
  parameter int WMAX   = iqf_pkg::WORD_MAX,
  parameter int BIDX_W = iqf_pkg::BIDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic [WMAX-1:0] i_word,
  input  logic [WMAX-1:0] q_word,
  input  logic [1:0]      len_sel,
  input  logic            serial_in,
  input  logic            prior_in,
  output logic            sending,
  output logic            pre,
  output logic            bit_i,
  output logic            bit_q,
  output logic            data_pos,
  output logic            lead_bit,
  output logic            act_serial,
  output logic            act_prior
);
  import iqf_pkg::*;

  seq_st_t           st;
  logic              pend;
  logic [WMAX-1:0]   hold_i, hold_q, act_i, act_q;
  logic [1:0]        act_len;
  logic [BIDX_W-1:0] bidx, slot_len, n_bits, p, last_idx;
  logic              second, start;
  logic [5:0]        widx;

  assign sending  = st == ST_SEND;
  assign pre      = st == ST_PRE;
  assign n_bits   = word_bits(act_len);
  assign slot_len = n_bits + BIDX_W'(2);
  assign last_idx = frame_bits(act_len, act_serial) - 1'b1;
  assign second   = act_serial && (bidx >= slot_len);
  assign p        = second ? bidx - slot_len : bidx;
  assign widx     = 6'(p - 1'b1);
  assign data_pos = sending && (p != '0) && (p <= n_bits);
  assign lead_bit = sending && (p == '0);
  assign bit_i    = data_pos && (second ? act_q[widx] : act_i[widx]);
  assign bit_q    = data_pos && !act_serial && act_q[widx];

  // start a frame on a boundary when idle or when the previous frame ends
  assign start = tick && pend &&
                 ((st == ST_IDLE) || (sending && (bidx == last_idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      hold_i <= '0;
      hold_q <= '0;
    end else begin
      pend <= load | (pend & ~start);
      if (load) begin
        hold_i <= i_word;
        hold_q <= q_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bidx       <= '0;
      act_i      <= '0;
      act_q      <= '0;
      act_len    <= 2'b00;
      act_serial <= 1'b0;
      act_prior  <= 1'b0;
    end else if (start) begin
      act_i      <= hold_i;
      act_q      <= hold_q;
      act_len    <= len_sel;
      act_serial <= serial_in;
      act_prior  <= prior_in;
      bidx       <= '0;
      st         <= prior_in ? ST_PRE : ST_SEND;
    end else if (tick) begin
      case (st)
        ST_PRE: begin
          st   <= ST_SEND;
          bidx <= '0;
        end
        ST_SEND: begin
          if (bidx == last_idx) st <= ST_IDLE;
          else                  bidx <= bidx + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iq_serial_framer.sv
module iq_serial_framer #(
  parameter int WMAX   = iqf_pkg::WORD_MAX,
  parameter int RATE_W = iqf_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WMAX-1:0]   i_word,
  input  logic [WMAX-1:0]   q_word,
  input  logic [1:0]        len_sel,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_iq_serial,
  input  logic              cfg_clk_gated,
  input  logic              cfg_clk_pulse,
  input  logic              cfg_clk_inv,
  input  logic              cfg_stb_prior,
  input  logic              cfg_stb_low,
  input  logic              cfg_en_i,
  input  logic              cfg_en_q,
  input  logic              cfg_en_clk,
  input  logic              cfg_en_stb,
  output logic              i_out,
  output logic              q_out,
  output logic              iqclk_out,
  output logic              iqstb_out,
  output logic              i_oe,
  output logic              q_oe,
  output logic              iqclk_oe,
  output logic              iqstb_oe
);
  logic tick, raw_clk, clk_active, strobe_act;
  logic seq_send, seq_pre, bit_i, bit_q, data_pos, lead_bit, act_serial, act_prior;

  iqf_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .rate(cfg_rate), .pulse(cfg_clk_pulse),
    .tick(tick), .raw_clk(raw_clk)
  );

  iqf_frame_seq #(.WMAX(WMAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .i_word(i_word), .q_word(q_word), .len_sel(len_sel),
    .serial_in(cfg_iq_serial), .prior_in(cfg_stb_prior),
    .sending(seq_send), .pre(seq_pre), .bit_i(bit_i), .bit_q(bit_q),
    .data_pos(data_pos), .lead_bit(lead_bit),
    .act_serial(act_serial), .act_prior(act_prior)
  );

  assign clk_active = cfg_clk_gated ? seq_send : (cfg_rate != '0);
  assign strobe_act = seq_pre || (data_pos && !act_prior);

  assign i_out     = bit_i;
  assign q_out     = bit_q;
  assign iqclk_out = (clk_active & raw_clk) ^ cfg_clk_inv;
  assign iqstb_out = strobe_act ^ cfg_stb_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_oe     <= 1'b0;
      q_oe     <= 1'b0;
      iqclk_oe <= 1'b0;
      iqstb_oe <= 1'b0;
    end else begin
      i_oe     <= cfg_en_i;
      q_oe     <= cfg_en_q;
      iqclk_oe <= cfg_en_clk;
      iqstb_oe <= cfg_en_stb;
    end
  end
endmodule

// File: rtl/iqf_checker.sv
module iqf_checker #(
  parameter int RATE_W = iqf_pkg::RATE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              seq_send,
  input logic              seq_pre,
  input logic              lead_bit,
  input logic              act_serial,
  input logic [RATE_W-1:0] cfg_rate,
  input logic              cfg_clk_gated,
  input logic              cfg_clk_inv,
  input logic              cfg_stb_low,
  input logic              i_out,
  input logic              q_out,
  input logic              iqclk_out,
  input logic              iqstb_out
);
  assert_lead_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lead_bit |-> (!i_out && !q_out));

  assert_serial_q_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_send && act_serial) |-> !q_out);

  assert_steady_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(seq_send) && $stable(seq_pre)));

  assert_rate_zero_clk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rate == '0) |-> (iqclk_out == cfg_clk_inv));

  assert_gated_clk_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_gated && !seq_send) |-> (iqclk_out == cfg_clk_inv));

  assert_prior_leads_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_pre && tick) |=> seq_send);

  assert_idle_strobe_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_send && !seq_pre) |-> (iqstb_out == cfg_stb_low));
endmodule

bind iq_serial_framer iqf_checker #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .seq_send(seq_send), .seq_pre(seq_pre),
  .lead_bit(lead_bit), .act_serial(act_serial), .cfg_rate(cfg_rate),
  .cfg_clk_gated(cfg_clk_gated), .cfg_clk_inv(cfg_clk_inv), .cfg_stb_low(cfg_stb_low),
  .i_out(i_out), .q_out(q_out), .iqclk_out(iqclk_out), .iqstb_out(iqstb_out)
);

// File: tb/iq_serial_framer_bench.sv
`timescale 1ns/100ps
module iq_serial_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [37:0] i_word = '0, q_word = '0;
  logic [1:0]  len_sel = 2'b00;
  logic [12:0] cfg_rate = '0;
  logic cfg_iq_serial = 0, cfg_clk_gated = 0, cfg_clk_pulse = 0, cfg_clk_inv = 0;
  logic cfg_stb_prior = 0, cfg_stb_low = 0;
  logic cfg_en_i = 0, cfg_en_q = 0, cfg_en_clk = 0, cfg_en_stb = 0;
  logic i_out, q_out, iqclk_out, iqstb_out, i_oe, q_oe, iqclk_oe, iqstb_oe;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  iq_serial_framer u_iq_serial_framer (
    .clk(clk), .rst_n(rst_n), .load(load), .i_word(i_word), .q_word(q_word),
    .len_sel(len_sel), .cfg_rate(cfg_rate), .cfg_iq_serial(cfg_iq_serial),
    .cfg_clk_gated(cfg_clk_gated), .cfg_clk_pulse(cfg_clk_pulse), .cfg_clk_inv(cfg_clk_inv),
    .cfg_stb_prior(cfg_stb_prior), .cfg_stb_low(cfg_stb_low),
    .cfg_en_i(cfg_en_i), .cfg_en_q(cfg_en_q), .cfg_en_clk(cfg_en_clk), .cfg_en_stb(cfg_en_stb),
    .i_out(i_out), .q_out(q_out), .iqclk_out(iqclk_out), .iqstb_out(iqstb_out),
    .i_oe(i_oe), .q_oe(q_oe), .iqclk_oe(iqclk_oe), .iqstb_oe(iqstb_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   mi[$], mq[$], md[$];
  int   m_ph = 0;
  bit   m_pre = 0, m_prior = 0, m_pend = 0;
  logic [37:0] m_hi = '0, m_hq = '0;
  bit   m_oe[4] = '{0, 0, 0, 0};

  function automatic int width_of(input logic [1:0] s);
    return (s == 2'b00) ? 16 : (s == 2'b01) ? 24 : (s == 2'b10) ? 32 : 38;
  endfunction

  task automatic push_word(input logic [37:0] w, input int n, input bit on_q);
    if (on_q) begin mq.push_back(0); end else begin mi.push_back(0); md.push_back(0); end
    for (int k = 0; k < n; k++) begin
      if (on_q) mq.push_back(w[k]); else begin mi.push_back(w[k]); md.push_back(1); end
    end
    if (on_q) begin mq.push_back(0); end else begin mi.push_back(0); md.push_back(0); end
  endtask

  task automatic build_frame();
    int n = width_of(len_sel);
    mi.delete(); mq.delete(); md.delete();
    push_word(m_hi, n, 0);
    if (cfg_iq_serial) begin
      push_word(m_hq, n, 0);
      for (int k = 0; k < mi.size(); k++) mq.push_back(0);
    end else begin
      push_word(m_hq, n, 1);
    end
    m_prior = cfg_stb_prior;
    m_pre   = cfg_stb_prior;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pre = 0; m_pend = 0; m_prior = 0;
      mi.delete(); mq.delete(); md.delete();
      m_oe = '{0, 0, 0, 0};
    end else begin
      bit tk;
      tk = (m_ph >= int'(cfg_rate));
      if (tk) begin
        if (m_pre) m_pre = 0;
        else if (mi.size() != 0) begin
          void'(mi.pop_front()); void'(mq.pop_front()); void'(md.pop_front());
        end
        if (!m_pre && mi.size() == 0 && m_pend) begin
          build_frame();
          m_pend = 0;
        end
      end
      m_ph = tk ? 0 : m_ph + 1;
      if (load) begin m_hi = i_word; m_hq = q_word; m_pend = 1; end
      m_oe = '{cfg_en_i, cfg_en_q, cfg_en_clk, cfg_en_stb};
    end
  end

  int rise_cnt = 0;
  logic prev_clk_pin = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit busy, ei, eq, act, raw, eclk, estb;
      int per;
      busy = !m_pre && mi.size() != 0;
      ei   = busy ? mi[0] : 0;
      eq   = busy ? mq[0] : 0;
      act  = m_pre || (busy && md[0] && !m_prior);
      per  = int'(cfg_rate) + 1;
      if (cfg_rate == 0)      raw = 0;
      else if (cfg_clk_pulse) raw = (m_ph == int'(cfg_rate));
      else                    raw = (m_ph >= per - per / 2);
      eclk = (cfg_clk_gated ? busy : (cfg_rate != 0)) ? (raw ^ cfg_clk_inv) : cfg_clk_inv;
      estb = act ^ cfg_stb_low;
      chk("R1 R2 R3 R11 R12 i_out", 64'(i_out), 64'(ei));
      chk("R1 R2 R3 q_out", 64'(q_out), 64'(eq));
      chk("R4 R5 R6 R7 iqclk_out", 64'(iqclk_out), 64'(eclk));
      chk("R8 R9 iqstb_out", 64'(iqstb_out), 64'(estb));
      chk("R10 oe", 64'({i_oe, q_oe, iqclk_oe, iqstb_oe}),
          64'({m_oe[0], m_oe[1], m_oe[2], m_oe[3]}));
      if (iqclk_out && !prev_clk_pin) rise_cnt++;
      prev_clk_pin = iqclk_out;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_pair(input logic [37:0] a, input logic [37:0] b);
    i_word = a; q_word = b; load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((m_pend || m_pre || mi.size() != 0) && guard < 50000) begin
      step(1); guard++;
    end
    step(3);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end

  initial begin
    step(3);
    // R10 reset state: enables and pins low
    chk("R10 reset oe", 64'({i_oe, q_oe, iqclk_oe, iqstb_oe}), 64'h0);
    chk("R1 reset data", 64'({i_out, q_out}), 64'h0);
    rst_n = 1'b1;
    cfg_en_i = 1; cfg_en_q = 1; cfg_en_clk = 1; cfg_en_stb = 1;
    step(1);
    cmp_on = 1;
    step(2);
    chk("R10 oe after enable", 64'({i_oe, q_oe, iqclk_oe, iqstb_oe}), 64'hf);

    // R2 R5: side by side, 16 bits, one bit per clock, spanning strobe
    cfg_rate = 0; len_sel = 2'b00;
    send_pair(38'h0000_00A5C3, 38'h0000_005A3C);
    wait_idle();

    // R3 R7: I then Q, 24 bits, period 4, continuous 50%
    cfg_rate = 3; cfg_iq_serial = 1; len_sel = 2'b01;
    send_pair(38'h0000_F0_0F11, 38'h0000_123456);
    wait_idle();

    // R6 R7 R8 R9: 38 bits, period 3, pulse clock, gated, inverted, prior low strobe
    cfg_rate = 2; cfg_iq_serial = 0; len_sel = 2'b11;
    cfg_clk_pulse = 1; cfg_clk_gated = 1; cfg_clk_inv = 1;
    cfg_stb_prior = 1; cfg_stb_low = 1;
    send_pair(38'h2A_BCDE_F012, 38'h15_4321_0FED);
    wait_idle();

    // R11: second load during frame is overwritten by a third, held till trailing zero
    cfg_rate = 1; cfg_iq_serial = 1; len_sel = 2'b10;
    cfg_clk_pulse = 0; cfg_clk_gated = 0; cfg_clk_inv = 0; cfg_stb_low = 0;
    send_pair(38'h00_8000_0001, 38'h00_7FFF_FFFE);
    step(10);
    send_pair(38'h00_1111_1111, 38'h00_2222_2222);
    step(5);
    send_pair(38'h00_DEAD_BEEF, 38'h00_0BAD_F00D);
    // R12: change length, mode and strobe timing mid-frame
    step(4);
    len_sel = 2'b00; cfg_iq_serial = 0; cfg_stb_prior = 0;
    wait_idle();

    // R1 all-ones 38 bits side by side, back-to-back loads at rate 0
    cfg_rate = 0; len_sel = 2'b11;
    send_pair({38{1'b1}}, {38{1'b1}});
    send_pair(38'h3F_0000_0001, 38'h00_0000_0000);
    wait_idle();

    // R4: slowest rate, continuous clock, count rising edges over 16384 cycles
    cfg_rate = 13'd8191; cfg_clk_gated = 0; cfg_clk_pulse = 0;
    step(8200);
    rise_cnt = 0;
    step(16384);
    chk("R4 edges in 16384 cycles at rate 8191", 64'(rise_cnt), 64'd2);

    // R10: enables drop one cycle later
    cfg_rate = 0;
    cfg_en_i = 0; cfg_en_clk = 0;
    step(2);
    chk("R10 oe after partial disable", 64'({i_oe, q_oe, iqclk_oe, iqstb_oe}), 64'h5);
    step(2);
    summary();
  end
endmodule